// File: doc/BRIEF.md
# Clock Source Selector with Counter Initialization

This block feeds a bit-rate divider chain. It chooses one of two slow clock sources and turns that choice into a one-cycle count enable on a single fast system clock. The first source is a crystal-derived level. The second is an external clock level, selected when an active-low enable input is driven low. Both source levels and the enable are sampled asynchronously, so each passes through a synchronizer before any decision is made.

The block also produces the master clear for the downstream scan counter and divider network. This clear does not come from power-on. It has two causes:

- While the crystal source is selected, any high level on the external clock holds the clear for as long as that level lasts.
- When the external source is first enabled, the first high phase of the external clock becomes the clear pulse. After that phase ends, the next rising edge of the external clock gives the first count enable.

No count enable is issued while the clear is active. A change of source never produces a count enable of its own.

Top module: `csi_clock_source`

## Requirements
- R1: One clock edge with `rst_n` low drives `mr_o` and `tick_o` low and discards any pending first-phase clear. After release in external mode, the first external rising edge gives a tick and no clear.
- R2: With `ext_en_n` high (crystal mode), each rising edge of `xtal_in` gives exactly one `tick_o` pulse, three system clocks later. A falling edge gives none.
- R3: With `ext_en_n` low (external mode), rising edges of `ext_clk_in` give the ticks, and `xtal_in` has no effect on `tick_o` or `mr_o`.
- R4: With `ext_en_n` high and `ext_clk_in` high, `mr_o` stays high for the whole high level, and `tick_o` stays low even if `xtal_in` rises.
- R5: After `ext_en_n` falls, the first high phase of `ext_clk_in` drives `mr_o` high for its whole duration and gives no tick.
- R6: Once that first high phase ends, the next rising edge of `ext_clk_in` gives a tick. Later high phases leave `mr_o` low.
- R7: If `ext_en_n` falls while `ext_clk_in` is already high, `mr_o` stays high without a gap until `ext_clk_in` goes low. The next rising edge then gives a tick.
- R8: `tick_o` and `mr_o` are never high in the same cycle.
- R9: A change of `ext_en_n` never gives a tick by itself, even when the newly selected level is higher than the old one.
- R10: `tick_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Synchronous active-low reset |
| xtal_in | input | 1 | Crystal-derived clock level, asynchronous |
| ext_clk_in | input | 1 | External clock level, asynchronous |
| ext_en_n | input | 1 | Low selects the external clock; high selects the crystal |
| src_level_o | output | 1 | Registered level of the currently selected source |
| tick_o | output | 1 | One-cycle count enable on a rising edge of the selected source |
| mr_o | output | 1 | Master clear for the downstream counters |

## Verification
Each fault in the internal state shows up at the ports within three or four system clocks of the input change that exposes it:

- A first-phase flag that never arms makes the clear pulse missing.
- A flag that never disarms swallows every later external tick.
- A stale source-select history produces a spurious tick on a mode change.

The bench counts ticks in a short window after every input step and samples the clear at the end of that window. This makes a lost, extra or early pulse visible at once.

// File: rtl/csi_pkg.sv
// Shared types and defaults for the clock source selector.
// Assumes a single system clock domain downstream of the synchronizers.
package csi_pkg;
    // Depth of every input synchronizer chain
    localparam int unsigned SYNC_DEPTH_DEF = 2;
    // Bit positions inside the synchronized input bundle
    localparam int unsigned IDX_XTAL = 0;
    localparam int unsigned IDX_EXT  = 1;
    localparam int unsigned IDX_EN_N = 2;
    localparam int unsigned IN_W     = 3;

    typedef enum logic {
        SRC_EXT  = 1'b0,
        SRC_XTAL = 1'b1
    } src_t;
endpackage

// File: rtl/csi_sync.sv
// Multi-bit, multi-stage synchronizer for independent asynchronous levels.
// Assumes each bit is a slow level; no bus coherency is provided.
module csi_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw asynchronous inputs
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= '0;
                    else        stg[0] <= d;
                end
            end else begin : g_next
                // Move the sample one stage further along the chain
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[s] <= '0;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/csi_init.sv
// Initialization circuit: produces the counter clear.
// The clear is held while the external clock is high in crystal mode.
// It is also pulsed during the first external high phase after the
// external source is enabled. Assumes synchronized inputs.
module csi_init (
    input  logic clk,
    input  logic rst_n,
    input  logic xtal_mode,    // synchronized, 1 = crystal selected
    input  logic ext_lvl,      // synchronized external clock level
    output logic clear_now,    // combinational clear request this cycle
    output logic mr_q,         // registered clear
    output logic armed_q       // first-phase flag
);
    logic mode_q;
    logic ext_q;
    logic en_fall;
    logic ext_fall;
    logic armed_d;

    assign en_fall   = mode_q & ~xtal_mode;
    assign ext_fall  = ext_q & ~ext_lvl;
    assign clear_now = ext_lvl & (xtal_mode | en_fall | armed_q);
    assign armed_d   = ~xtal_mode & (en_fall | (armed_q & ~ext_fall));

    // Keep one cycle of history on the mode and the external level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            ext_q  <= 1'b0;
        end else begin
            mode_q <= xtal_mode;
            ext_q  <= ext_lvl;
        end
    end

    // Arm on entry to external mode, disarm when the first high phase ends
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= armed_d;
    end

    // Register the clear for a glitch-free output
    always_ff @(posedge clk) begin
        if (!rst_n) mr_q <= 1'b0;
        else        mr_q <= clear_now;
    end
endmodule

// File: rtl/csi_src_mux.sv
// Source selector and rising-edge detector.
// Emits a one-cycle tick per rising edge of the selected level.
// Suppresses ticks while a clear is requested or in the cycle the
// selection changes. Assumes synchronized inputs.
module csi_src_mux
    import csi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xtal_mode,
    input  logic xtal_lvl,
    input  logic ext_lvl,
    input  logic clear_now,
    output logic lvl_q,
    output logic tick_q
);
    src_t sel;
    logic sel_q;
    logic lvl;
    logic tick_d;

    assign sel    = xtal_mode ? SRC_XTAL : SRC_EXT;
    assign lvl    = (sel == SRC_XTAL) ? xtal_lvl : ext_lvl;
    assign tick_d = lvl & ~lvl_q & ~clear_now & ~(sel_q ^ xtal_mode);

    // Track the previous level and the previous selection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
            sel_q <= 1'b0;
        end else begin
            lvl_q <= lvl;
            sel_q <= xtal_mode;
        end
    end

    // Register the count enable
    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= tick_d;
    end
endmodule

// File: rtl/csi_clock_source.sv
// Top level: synchronizes the inputs, selects the clock source and
// generates the counter clear. Assumes clk is many times faster than
// both source clocks.
module csi_clock_source
    import csi_pkg::*;
#(
    parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xtal_in,
    input  logic ext_clk_in,
    input  logic ext_en_n,
    output logic src_level_o,
    output logic tick_o,
    output logic mr_o
);
    logic [IN_W-1:0] raw;
    logic [IN_W-1:0] syn;
    logic            clear_now;
    logic            armed;

    assign raw[IDX_XTAL] = xtal_in;
    assign raw[IDX_EXT]  = ext_clk_in;
    assign raw[IDX_EN_N] = ext_en_n;

    csi_sync #(.WIDTH(IN_W), .STAGES(SYNC_DEPTH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw),
        .q     (syn)
    );

    csi_init u_init (
        .clk       (clk),
        .rst_n     (rst_n),
        .xtal_mode (syn[IDX_EN_N]),
        .ext_lvl   (syn[IDX_EXT]),
        .clear_now (clear_now),
        .mr_q      (mr_o),
        .armed_q   (armed)
    );

    csi_src_mux u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .xtal_mode (syn[IDX_EN_N]),
        .xtal_lvl  (syn[IDX_XTAL]),
        .ext_lvl   (syn[IDX_EXT]),
        .clear_now (clear_now),
        .lvl_q     (src_level_o),
        .tick_q    (tick_o)
    );
endmodule

// File: rtl/csi_clock_source_chk.sv
// Property checker for csi_clock_source, attached by bind.
module csi_clock_source_chk (
    input logic clk,
    input logic rst_n,
    input logic tick_o,
    input logic mr_o,
    input logic xtal_mode,
    input logic ext_lvl,
    input logic armed
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!mr_o && !tick_o));

    // R4
    hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xtal_mode && ext_lvl) |=> mr_o);

    // R6
    disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !ext_lvl && $past(ext_lvl)) |=> !armed);

    // R8
    no_tick_in_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_o && mr_o));

    // R10
    single_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

bind csi_clock_source csi_clock_source_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_o    (tick_o),
    .mr_o      (mr_o),
    .xtal_mode (syn[csi_pkg::IDX_EN_N]),
    .ext_lvl   (syn[csi_pkg::IDX_EXT]),
    .armed     (armed)
);

// File: tb/tb_csi_clock_source.sv
module tb_csi_clock_source;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xtal_in = 1'b0;
    logic ext_clk_in = 1'b0;
    logic ext_en_n = 1'b1;
    logic src_level_o;
    logic tick_o;
    logic mr_o;

    int total = 0;
    int bad = 0;
    int overlap = 0;
    int ticks;
    bit done = 0;

    always #2.5 clk = ~clk;

    csi_clock_source dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .xtal_in     (xtal_in),
        .ext_clk_in  (ext_clk_in),
        .ext_en_n    (ext_en_n),
        .src_level_o (src_level_o),
        .tick_o      (tick_o),
        .mr_o        (mr_o)
    );

    // Vector fields: {ext_en_n, xtal_in, ext_clk_in, exp_mr, exp_tick}
    localparam int NV = 23;
    localparam logic [4:0] VEC [NV] = '{
        5'b1_1_0_0_1, // R2 xtal rise
        5'b1_0_0_0_0, // R2 xtal fall
        5'b1_1_0_0_1, // R2
        5'b1_0_0_0_0, // R2
        5'b1_0_1_1_0, // R4 ext high in crystal mode
        5'b1_1_1_1_0, // R4 xtal rise masked
        5'b1_1_0_0_0, // R4 release
        5'b1_0_0_0_0, // R2
        5'b0_0_0_0_0, // R9 enter external mode
        5'b0_1_0_0_0, // R3 xtal ignored
        5'b0_1_1_1_0, // R5 first high phase
        5'b0_1_0_0_0, // R5 end of phase
        5'b0_1_1_0_1, // R6 next rise counts
        5'b0_1_0_0_0, // R6
        5'b0_1_1_0_1, // R6 later high, no clear
        5'b0_1_0_0_0, // R3
        5'b1_1_0_0_0, // R9 back to crystal, level higher
        5'b1_0_0_0_0, // R2
        5'b1_1_0_0_1, // R2
        5'b1_1_1_1_0, // R7 clear held
        5'b0_1_1_1_0, // R7 enable falls during high
        5'b0_1_0_0_0, // R7
        5'b0_1_1_0_1  // R7 next rise counts
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Wait a window of cycles, counting ticks and tick/clear overlaps
    task automatic window(input int n);
        ticks = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (tick_o) ticks++;
            if (tick_o && mr_o) overlap++;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 mr after reset", int'(mr_o), 0);
        check("R1 tick after reset", int'(tick_o), 0);
        rst_n = 1'b1;
        window(5);

        for (int v = 0; v < NV; v++) begin
            ext_en_n   = VEC[v][4];
            xtal_in    = VEC[v][3];
            ext_clk_in = VEC[v][2];
            window(5);
            check($sformatf("vec%0d mr (R2-R7 table)", v), int'(mr_o), int'(VEC[v][1]));
            check($sformatf("vec%0d ticks (R2-R7 table)", v), ticks, int'(VEC[v][0]));
        end

        // R1: reset discards a pending first-phase clear
        ext_clk_in = 1'b0; xtal_in = 1'b0; ext_en_n = 1'b1;
        window(5);
        ext_en_n = 1'b0;
        window(5);
        rst_n = 1'b0;
        window(2);
        check("R1 mr in reset", int'(mr_o), 0);
        check("R1 tick in reset", int'(tick_o), 0);
        rst_n = 1'b1;
        window(5);
        ext_clk_in = 1'b1;
        window(5);
        check("R1 mr after arm discarded", int'(mr_o), 0);
        check("R1 tick after arm discarded", ticks, 1);

        // R8: no tick ever coincided with a clear
        check("R8 tick/clear overlap", overlap, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        done = 1;
        $finish;
    end

    initial begin
        repeat (20000) @(negedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule